// File: doc/BRIEF.md
# DDR3 Rank Mode-Register Initialization Sequencer

This block brings each populated DDR3 rank out of power-up by driving the standard mode-register programming sequence onto a registered command/address bus. The bus carries a 4-bit command code, a bank address, a row address and a one-hot rank select. A one-cycle start pulse launches the run. Ranks are visited from the lowest index upward, and ranks whose population bit is clear are skipped. For each rank the block issues a power-up NOP that is held for a long settling interval. It then writes the four mode registers in the order MR2, MR3, MR1, MR0, and finishes with a long ZQ calibration.

Every command is held on the bus for a programmable number of clock cycles. The bus then returns to the normal-operation code for a programmable gap before the next command. All three intervals are parameters counted in clock cycles, so a bench can shorten them. The mode-register words are built from these inputs: CAS latency, write recovery, a write-latency frequency index, and per-rank termination codes. On an odd rank whose module is flagged as address-mirrored, selected address and bank bits are swapped before the command goes out. A resume-boot input skips the whole sequence. A done flag reports completion.

Top module: `ddr3_mr_sequencer`

## Requirements
- R1: After reset, cmd_o is 0 (normal operation), cs_o is all zero, and busy_o and done_o are low.
- R2: For every populated rank, in ascending rank order, the block issues six commands in this order: NOP (code 1, bank 0), MR2 (code 4, bank 2), MR3 (code 5, bank 3), MR1 (code 3, bank 1), MR0 (code 2, bank 0) and ZQ calibration (code 6, bank 0). Unpopulated ranks get no command. cs_o has exactly the bit of the addressed rank set.
- R3: The MR2 word holds freq_idx_i in address bits 5:3 and the rank's 2-bit write-termination code (rtt_wr_i[2r+1:2r]) in bits 10:9. All other address bits are zero.
- R4: The MR1 word holds the rank's 3-bit nominal-termination code (rtt_nom_i[3r+2:3r]) in bits 4:2 and sets bit 1. All other address bits are zero.
- R5: The MR0 word sets bits 3, 8 and 12, holds cas_lat_i minus 4 in bits 6:4 and wr_rec_i minus 4 in bits 11:9. All other address bits are zero.
- R6: The ZQ calibration command carries only address bit 10. The NOP and MR3 commands carry an all-zero address.
- R7: When rank r is odd and dimm_mirror_i[r/2] is set, every command word for that rank has address bits 3↔4, 5↔6 and 7↔8 swapped and bank bits 0↔1 swapped. Even ranks and unflagged modules are never swapped.
- R8: The NOP is held unchanged for POWERUP_CYC cycles and every other command for HOLD_CYC cycles. After each command the bus shows code 0 with cs_o zero for GAP_CYC cycles.
- R9: A start pulse with resume_i high issues no command and raises done_o on the next cycle with busy_o low.
- R10: done_o rises, and busy_o falls, after the gap that follows the last populated rank's ZQ command. With no rank populated, done_o rises on the cycle after start with no command issued.
- R11: A start pulse while busy_o is high is ignored, whatever the value of resume_i. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| resume_i | input | 1 | Skip the sequence (resume boot) |
| rank_present_i | input | NUM_RANKS | Population mask, one bit per rank |
| dimm_mirror_i | input | NUM_RANKS/2 | Address-mirrored flag per module (two ranks each) |
| cas_lat_i | input | 4 | CAS latency in clocks |
| wr_rec_i | input | 4 | Write recovery in clocks |
| freq_idx_i | input | 3 | Write-latency index (CWL minus 5) |
| rtt_nom_i | input | 3*NUM_RANKS | Nominal termination code per rank |
| rtt_wr_i | input | 2*NUM_RANKS | Write termination code per rank |
| cmd_o | output | 4 | Command code (0 normal, 1 NOP, 2..5 MR0..MR3, 6 ZQ long) |
| ba_o | output | 3 | Bank address |
| addr_o | output | 16 | Row address |
| cs_o | output | NUM_RANKS | One-hot rank select |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished; cleared by the next accepted start |

## Verification
The assertions assume three things about the inputs. The configuration inputs (mask, mirror flags, timing values, termination codes) hold still from the start pulse until done_o rises. cas_lat_i and wr_rec_i lie in 4 to 11, so that the minus-4 fields fit in three bits. The three interval parameters are at least one. The stimulus changes configuration only while the block is idle, and it drives start only as single-cycle pulses. Its one start inside a busy run is the deliberate check of R11. Cases with an address word that has ones in bits 3 to 8 are chosen so that a wrong or missing swap changes the compared value.

// File: rtl/ddr3_seq_pkg.sv
package ddr3_seq_pkg;

  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;

  typedef enum logic [3:0] {
    CMD_NORMAL = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_MODE0  = 4'd2,
    CMD_MODE1  = 4'd3,
    CMD_MODE2  = 4'd4,
    CMD_MODE3  = 4'd5,
    CMD_ZQLONG = 4'd6
  } seq_cmd_e;

  typedef enum logic [2:0] {
    STEP_NOP = 3'd0,
    STEP_MR2 = 3'd1,
    STEP_MR3 = 3'd2,
    STEP_MR1 = 3'd3,
    STEP_MR0 = 3'd4,
    STEP_ZQ  = 3'd5
  } seq_step_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_HOLD = 2'd1,
    FSM_GAP  = 2'd2
  } seq_fsm_e;

endpackage

// File: rtl/ddr3_addr_mirror.sv
module ddr3_addr_mirror
  import ddr3_seq_pkg::*;
#(
  parameter int SWAP_LO = 3,
  parameter int SWAP_HI = 8
) (
  input  logic              en,
  input  logic [ROW_W-1:0]  addr_in,
  input  logic [BANK_W-1:0] ba_in,
  output logic [ROW_W-1:0]  addr_out,
  output logic [BANK_W-1:0] ba_out
);

  // Adjacent pairs starting at SWAP_LO trade places when enabled.
  for (genvar g = 0; g < ROW_W; g++) begin : g_row
    if (g >= SWAP_LO && g <= SWAP_HI) begin : g_sw
      localparam int PEER = (((g - SWAP_LO) % 2) == 0) ? g + 1 : g - 1;
      assign addr_out[g] = en ? addr_in[PEER] : addr_in[g];
    end else begin : g_pass
      assign addr_out[g] = addr_in[g];
    end
  end

  assign ba_out = en ? {ba_in[BANK_W-1:2], ba_in[0], ba_in[1]} : ba_in;

endmodule

// File: rtl/ddr3_mr_word.sv
module ddr3_mr_word
  import ddr3_seq_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  localparam int RK_W  = $clog2(NUM_RANKS),
  localparam int DIMMS = NUM_RANKS / 2,
  localparam int DM_W  = (DIMMS > 1) ? $clog2(DIMMS) : 1
) (
  input  seq_step_e               step,
  input  logic [RK_W-1:0]         rank_idx,
  input  logic [3:0]              cas_lat,
  input  logic [3:0]              wr_rec,
  input  logic [2:0]              freq_idx,
  input  logic [3*NUM_RANKS-1:0]  rtt_nom,
  input  logic [2*NUM_RANKS-1:0]  rtt_wr,
  input  logic [DIMMS-1:0]        dimm_mirror,
  output seq_cmd_e                cmd,
  output logic [BANK_W-1:0]       ba,
  output logic [ROW_W-1:0]        addr
);

  logic [ROW_W-1:0]  raw_addr;
  logic [BANK_W-1:0] raw_ba;
  logic [2:0]        nom_code;
  logic [1:0]        wr_code;
  logic [DM_W-1:0]   dimm_idx;
  logic              swap_en;

  assign nom_code = rtt_nom[int'(rank_idx)*3 +: 3];
  assign wr_code  = rtt_wr[int'(rank_idx)*2 +: 2];
  assign dimm_idx = DM_W'(rank_idx >> 1);
  assign swap_en  = rank_idx[0] & dimm_mirror[dimm_idx];

  always_comb begin
    raw_addr = '0;
    raw_ba   = '0;
    cmd      = CMD_NOP;
    case (step)
      STEP_MR2: begin
        cmd           = CMD_MODE2;
        raw_ba        = BANK_W'(2);
        raw_addr[5:3]  = freq_idx;
        raw_addr[10:9] = wr_code;
      end
      STEP_MR3: begin
        cmd    = CMD_MODE3;
        raw_ba = BANK_W'(3);
      end
      STEP_MR1: begin
        cmd           = CMD_MODE1;
        raw_ba        = BANK_W'(1);
        raw_addr[4:2] = nom_code;
        raw_addr[1]   = 1'b1;
      end
      STEP_MR0: begin
        cmd            = CMD_MODE0;
        raw_addr[3]    = 1'b1;
        raw_addr[8]    = 1'b1;
        raw_addr[12]   = 1'b1;
        raw_addr[6:4]  = 3'(cas_lat - 4'd4);
        raw_addr[11:9] = 3'(wr_rec - 4'd4);
      end
      STEP_ZQ: begin
        cmd          = CMD_ZQLONG;
        raw_addr[10] = 1'b1;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  ddr3_addr_mirror u_mirror (
    .en       (swap_en),
    .addr_in  (raw_addr),
    .ba_in    (raw_ba),
    .addr_out (addr),
    .ba_out   (ba)
  );

endmodule

// File: rtl/ddr3_dwell_timer.sv
module ddr3_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_n = load_val;
    else      cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  AST_TMR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R8
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R8

endmodule

// File: rtl/ddr3_mr_sequencer.sv
module ddr3_mr_sequencer
  import ddr3_seq_pkg::*;
#(
  parameter int NUM_RANKS   = 4,
  parameter int POWERUP_CYC = 160000,
  parameter int HOLD_CYC    = 8000,
  parameter int GAP_CYC     = 800,
  localparam int RK_W    = $clog2(NUM_RANKS),
  localparam int DIMMS   = NUM_RANKS / 2,
  localparam int MAX_A   = (POWERUP_CYC > HOLD_CYC) ? POWERUP_CYC : HOLD_CYC,
  localparam int MAX_CYC = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    resume_i,
  input  logic [NUM_RANKS-1:0]    rank_present_i,
  input  logic [DIMMS-1:0]        dimm_mirror_i,
  input  logic [3:0]              cas_lat_i,
  input  logic [3:0]              wr_rec_i,
  input  logic [2:0]              freq_idx_i,
  input  logic [3*NUM_RANKS-1:0]  rtt_nom_i,
  input  logic [2*NUM_RANKS-1:0]  rtt_wr_i,
  output logic [3:0]              cmd_o,
  output logic [BANK_W-1:0]       ba_o,
  output logic [ROW_W-1:0]        addr_o,
  output logic [NUM_RANKS-1:0]    cs_o,
  output logic                    busy_o,
  output logic                    done_o
);

  seq_fsm_e  state_q, state_n;
  seq_step_e step_q, step_n, step_t;
  logic [RK_W-1:0] rank_q, rank_n, rank_t;
  logic done_q, done_n;

  logic [3:0]           cmd_q, cmd_n;
  logic [BANK_W-1:0]    ba_q, ba_n;
  logic [ROW_W-1:0]     addr_q, addr_n;
  logic [NUM_RANKS-1:0] cs_q, cs_n;
  logic                 out_en;

  logic issue, go_normal;
  logic tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  logic first_ok, next_ok;
  logic [RK_W-1:0] first_idx, next_idx;

  seq_cmd_e          w_cmd;
  logic [BANK_W-1:0] w_ba;
  logic [ROW_W-1:0]  w_addr;

  // Lowest populated rank overall, and lowest one above the current rank.
  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    next_ok   = 1'b0;
    next_idx  = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (rank_present_i[i]) begin
        first_ok  = 1'b1;
        first_idx = RK_W'(i);
      end
      if (rank_present_i[i] && (i > int'(rank_q))) begin
        next_ok  = 1'b1;
        next_idx = RK_W'(i);
      end
    end
  end

  // Next-state logic.
  always_comb begin
    state_n   = state_q;
    done_n    = done_q;
    step_t    = step_q;
    rank_t    = rank_q;
    issue     = 1'b0;
    go_normal = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state_q)
      FSM_IDLE: begin
        if (start_i) begin
          if (resume_i || !first_ok) begin
            done_n = 1'b1;
          end else begin
            done_n   = 1'b0;
            issue    = 1'b1;
            rank_t   = first_idx;
            step_t   = STEP_NOP;
            state_n  = FSM_HOLD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(POWERUP_CYC - 1);
          end
        end
      end
      FSM_HOLD: begin
        if (tmr_zero) begin
          go_normal = 1'b1;
          state_n   = FSM_GAP;
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(GAP_CYC - 1);
        end
      end
      FSM_GAP: begin
        if (tmr_zero) begin
          if (step_q != STEP_ZQ) begin
            issue    = 1'b1;
            step_t   = seq_step_e'(step_q + 3'd1);
            state_n  = FSM_HOLD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HOLD_CYC - 1);
          end else if (next_ok) begin
            issue    = 1'b1;
            rank_t   = next_idx;
            step_t   = STEP_NOP;
            state_n  = FSM_HOLD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(POWERUP_CYC - 1);
          end else begin
            state_n = FSM_IDLE;
            done_n  = 1'b1;
          end
        end
      end
      default: state_n = FSM_IDLE;
    endcase
    step_n = step_t;
    rank_n = rank_t;
  end

  ddr3_mr_word #(.NUM_RANKS(NUM_RANKS)) u_word (
    .step        (step_t),
    .rank_idx    (rank_t),
    .cas_lat     (cas_lat_i),
    .wr_rec      (wr_rec_i),
    .freq_idx    (freq_idx_i),
    .rtt_nom     (rtt_nom_i),
    .rtt_wr      (rtt_wr_i),
    .dimm_mirror (dimm_mirror_i),
    .cmd         (w_cmd),
    .ba          (w_ba),
    .addr        (w_addr)
  );

  // Bus next values: a new command, the return to normal, or hold.
  assign out_en = issue | go_normal;

  always_comb begin
    if (issue) begin
      cmd_n  = w_cmd;
      ba_n   = w_ba;
      addr_n = w_addr;
      cs_n   = NUM_RANKS'(1) << rank_t;
    end else begin
      cmd_n  = CMD_NORMAL;
      ba_n   = '0;
      addr_n = '0;
      cs_n   = '0;
    end
  end

  ddr3_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      step_q  <= STEP_NOP;
      rank_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      if (issue) begin
        step_q <= step_n;
        rank_q <= rank_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NORMAL;
      ba_q   <= '0;
      addr_q <= '0;
      cs_q   <= '0;
    end else if (out_en) begin
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
      cs_q   <= cs_n;
    end
  end

  assign cmd_o  = cmd_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;
  assign cs_o   = cs_q;
  assign busy_o = (state_q != FSM_IDLE);
  assign done_o = done_q;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_q)); // R2
  AST_CS_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NORMAL) |-> (cs_q == '0)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSM_HOLD && !tmr_zero) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(ba_q))); // R8
  AST_NOP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) |-> (addr_q == '0)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == FSM_IDLE)); // R10
  AST_RESUME_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSM_IDLE && start_i && resume_i) |=> (done_q && cmd_q == CMD_NORMAL)); // R9
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSM_HOLD && !tmr_zero && start_i) |=> (state_q == FSM_HOLD)); // R11

endmodule

// File: tb/ddr3_mr_sequencer_test.sv
module ddr3_mr_sequencer_test;

  localparam int NR  = 4;
  localparam int PUP = 20;
  localparam int HLD = 5;
  localparam int GAP = 3;

  logic clk, rst_n, start_i, resume_i;
  logic [NR-1:0]   rank_present_i;
  logic [NR/2-1:0] dimm_mirror_i;
  logic [3:0]      cas_lat_i, wr_rec_i;
  logic [2:0]      freq_idx_i;
  logic [3*NR-1:0] rtt_nom_i;
  logic [2*NR-1:0] rtt_wr_i;
  logic [3:0]      cmd_o;
  logic [2:0]      ba_o;
  logic [15:0]     addr_o;
  logic [NR-1:0]   cs_o;
  logic            busy_o, done_o;

  ddr3_mr_sequencer #(.NUM_RANKS(NR), .POWERUP_CYC(PUP), .HOLD_CYC(HLD), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
    .rank_present_i(rank_present_i), .dimm_mirror_i(dimm_mirror_i),
    .cas_lat_i(cas_lat_i), .wr_rec_i(wr_rec_i), .freq_idx_i(freq_idx_i),
    .rtt_nom_i(rtt_nom_i), .rtt_wr_i(rtt_wr_i),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .cs_o(cs_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [3:0]  q_cmd[$];
  logic [2:0]  q_ba[$];
  logic [15:0] q_addr[$];
  logic [3:0]  q_cs[$];
  int          q_len[$];
  int          q_gap[$];
  string       q_tag[$];

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      summary_and_end();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] swap_pairs(input logic [15:0] a);
    logic [15:0] m;
    m = a & ~16'h01F8;
    m = m | ((a & 16'h00A8) << 1);
    m = m | ((a & 16'h0150) >> 1);
    return m;
  endfunction

  // Scoreboard driver side: push the six expected items for one rank.
  task automatic push_rank(input int r, input bit first);
    logic [3:0] c[6];
    logic [2:0] b[6];
    logic [15:0] a[6];
    string t[6];
    bit mir;
    mir = (r % 2 == 1) && dimm_mirror_i[r/2];
    c[0] = 4'd1; b[0] = 3'd0; a[0] = 16'h0;  t[0] = "R2 R8 NOP";
    c[1] = 4'd4; b[1] = 3'd2;
    a[1] = (16'(freq_idx_i) << 3) | (16'(rtt_wr_i[2*r +: 2]) << 9); t[1] = "R3 MR2";
    c[2] = 4'd5; b[2] = 3'd3; a[2] = 16'h0;  t[2] = "R6 MR3";
    c[3] = 4'd3; b[3] = 3'd1;
    a[3] = (16'(rtt_nom_i[3*r +: 3]) << 2) | 16'h2; t[3] = "R4 MR1";
    c[4] = 4'd2; b[4] = 3'd0;
    a[4] = 16'h1108 | (16'(cas_lat_i - 4'd4) << 4) | (16'(wr_rec_i - 4'd4) << 9); t[4] = "R5 MR0";
    c[5] = 4'd6; b[5] = 3'd0; a[5] = 16'h0400; t[5] = "R6 ZQ";
    for (int k = 0; k < 6; k++) begin
      q_cmd.push_back(c[k]);
      q_ba.push_back(mir ? {b[k][2], b[k][0], b[k][1]} : b[k]);
      q_addr.push_back(mir ? swap_pairs(a[k]) : a[k]);
      q_cs.push_back(4'(1 << r));
      q_len.push_back(k == 0 ? PUP : HLD);
      q_gap.push_back((first && k == 0) ? 0 : GAP);
      q_tag.push_back(mir ? {t[k], " R7"} : t[k]);
    end
  endtask

  // Monitor side.
  int run_len = 0;
  int gap_cnt = 0;
  int cap_gap = 0;
  bit unstable = 0;
  bit cs_leak = 0;
  logic [3:0]  cap_cmd;
  logic [2:0]  cap_ba;
  logic [15:0] cap_addr;
  logic [3:0]  cap_cs;

  task automatic finish_item();
    logic [3:0] ec; logic [2:0] eb; logic [15:0] ea; logic [3:0] es;
    int el, eg; string et;
    checks++;
    if (q_cmd.size() == 0) begin
      fails++;
      $display("FAIL R2 unexpected command: actual cmd %0h addr %0h expected none", cap_cmd, cap_addr);
    end else begin
      ec = q_cmd.pop_front(); eb = q_ba.pop_front(); ea = q_addr.pop_front();
      es = q_cs.pop_front();  el = q_len.pop_front(); eg = q_gap.pop_front();
      et = q_tag.pop_front();
      if (cap_cmd !== ec || cap_ba !== eb || cap_addr !== ea || cap_cs !== es ||
          run_len != el || cap_gap != eg || unstable) begin
        fails++;
        $display("FAIL %s: actual cmd %0h ba %0h addr %0h cs %0h len %0d gap %0d unstable %0d / expected cmd %0h ba %0h addr %0h cs %0h len %0d gap %0d",
                 et, cap_cmd, cap_ba, cap_addr, cap_cs, run_len, cap_gap, unstable,
                 ec, eb, ea, es, el, eg);
      end
    end
    unstable = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_o == 4'd0 && cs_o != '0) cs_leak = 1;
      if (cmd_o != 4'd0) begin
        if (run_len == 0) begin
          cap_cmd = cmd_o; cap_ba = ba_o; cap_addr = addr_o; cap_cs = cs_o;
          cap_gap = gap_cnt;
          gap_cnt = 0;
        end else if (cmd_o !== cap_cmd || ba_o !== cap_ba || addr_o !== cap_addr || cs_o !== cap_cs) begin
          unstable = 1;
        end
        run_len++;
      end else begin
        if (run_len > 0) finish_item();
        run_len = 0;
        if (busy_o) gap_cnt++;
        else gap_cnt = 0;
      end
    end
  end

  task automatic pulse_start(input bit res);
    @(negedge clk);
    resume_i = res;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    resume_i = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
  endtask

  task automatic run_seq(input logic [3:0] mask, input logic [1:0] mir,
                         input logic [3:0] cas, input logic [3:0] twr, input logic [2:0] fr,
                         input logic [11:0] nom, input logic [7:0] wr, input bit poke);
    bit first;
    @(negedge clk);
    rank_present_i = mask; dimm_mirror_i = mir; cas_lat_i = cas; wr_rec_i = twr;
    freq_idx_i = fr; rtt_nom_i = nom; rtt_wr_i = wr;
    first = 1;
    for (int r = 0; r < NR; r++) begin
      if (mask[r]) begin
        push_rank(r, first);
        first = 0;
      end
    end
    cs_leak = 0;
    pulse_start(1'b0);
    if (poke) begin
      repeat (30) @(negedge clk);
      pulse_start(1'b1); // R11: start with resume while busy must be ignored
    end
    wait_done(3000);
    check(done_o && !busy_o, "R10 done after last rank", {done_o, busy_o}, 2'b10);
    check(q_cmd.size() == 0, "R11 R2 all expected commands seen", q_cmd.size(), 0);
    check(!cs_leak, "R8 cs low during normal gap", cs_leak, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; resume_i = 1'b0;
    rank_present_i = '0; dimm_mirror_i = '0; cas_lat_i = 4'd6; wr_rec_i = 4'd6;
    freq_idx_i = '0; rtt_nom_i = '0; rtt_wr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_o == 4'd0 && cs_o == '0 && !busy_o && !done_o, "R1 reset state",
          {cmd_o, cs_o, busy_o, done_o}, 0);

    // All ranks, both modules mirrored, a start poked mid-run.
    run_seq(4'b1111, 2'b11, 4'd6, 4'd6, 3'd2, {3'd4, 3'd3, 3'd2, 3'd1}, {2'd1, 2'd2, 2'd1, 2'd2}, 1'b1);
    // Odd ranks only, first module mirrored: rank 1 swapped, rank 3 not.
    run_seq(4'b1010, 2'b01, 4'd11, 4'd8, 3'd5, {3'd5, 3'd7, 3'd6, 3'd1}, {2'd3, 2'd1, 2'd2, 2'd3}, 1'b0);
    // Even ranks only with mirror flags set: no swapping (R7).
    run_seq(4'b0101, 2'b11, 4'd9, 4'd7, 3'd3, {3'd2, 3'd6, 3'd3, 3'd5}, {2'd2, 2'd3, 2'd1, 2'd2}, 1'b0);
    // Single top rank, mirrored module.
    run_seq(4'b1000, 2'b10, 4'd5, 4'd11, 3'd7, {3'd7, 3'd0, 3'd0, 3'd0}, {2'd3, 2'd0, 2'd0, 2'd0}, 1'b0);

    // Resume boot: no command, done on the next cycle.
    rank_present_i = 4'b1111;
    pulse_start(1'b1);
    check(done_o && !busy_o && cmd_o == 4'd0, "R9 resume skips sequence", {done_o, busy_o, cmd_o}, 6'b100000);
    repeat (40) @(negedge clk);
    check(cmd_o == 4'd0 && !busy_o, "R9 no command after resume", {busy_o, cmd_o}, 0);

    // Empty population mask.
    rank_present_i = 4'b0000;
    pulse_start(1'b0);
    check(done_o && !busy_o, "R10 empty mask finishes at once", {done_o, busy_o}, 2'b10);
    repeat (40) @(negedge clk);
    check(cmd_o == 4'd0 && cs_o == '0, "R10 empty mask issues nothing", {cmd_o, cs_o}, 0);

    summary_and_end();
  end

endmodule